// File: doc/BRIEF.md
# Separate-I/O Burst-of-Two SRAM Engine

This block is a synchronous memory with independent write-data and read-data buses that share one word address and one clock. A command is loaded on each rising edge from two active-low strobes. Every command moves exactly two data beats. The block generates the lowest array-index bit internally, so the external address is one bit narrower than the array index. Whether a strobe is honoured depends on the command loaded on the previous edge. Two reads in a row, or two writes in a row, are never started, which suits traffic where reads and writes alternate.

Write beats carry active-low byte enables, one per 9-bit lane. Read beats are registered. A read-data-valid signal marks the cycles in which the read bus would be driven, and it is low in every other cycle. An echo-valid indication stays high from the end of reset onward, whatever commands arrive. The array is written as early as the write pipeline permits. A read issued right after a write therefore always returns the fresh data.

Top module: `sepio_burst_sram`

## Requirements
- R1: Address and strobes are sampled on every rising edge. With both `readN` and `writeN` high, no transfer begins, and `rdOe` is low two cycles later unless an earlier read is still delivering.
- R2: A low `readN` starts a read whenever the previous loaded command was not a read. This holds even when `writeN` is also low. A low `readN` right after a loaded read is ignored.
- R3: A low `writeN` with `readN` high starts a write unless the previous loaded command was a write. A low `writeN` right after a loaded write is ignored, and nothing is stored for it.
- R4: When the previous loaded command was a read, a low `writeN` starts a write whatever level `readN` has.
- R5: Each command covers two array words. Beat 0 uses index {addr,0} and beat 1 uses index {addr,1}.
- R6: Write data and byte enables for beat 0 are taken on the first rising edge after the write command. Beat 1 is taken on the edge after that.
- R7: For a read loaded at edge k, beat 0 appears on `rdData` after edge k+1 and beat 1 after edge k+2. `rdOe` is high in exactly those cycles.
- R8: `byteEnN[i]` low writes lane i (bits 9i+8 down to 9i) of the beat. When it is high, that stored lane is left unchanged. With all enables high on both beats, nothing is stored.
- R9: A read of a location loaded immediately after a write to it returns the newly written data.
- R10: `rdOe` is low in every cycle that carries no read beat. This covers the cycle after a deselect or write, unless a read came just before.
- R11: After reset, `echoValid` is high in every cycle, including deselects and cycles in which the read strobe is held high.
- R12: A synchronous reset makes the previous command a deselect and forces `rdOe` and `echoValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Word-pair address (index without its LSB) |
| readN | input | 1 | Read strobe, active low |
| writeN | input | 1 | Write strobe, active low |
| wrData | input | 9*LANES | Write beat data |
| byteEnN | input | LANES | Per-lane write enables, active low |
| rdData | output | 9*LANES | Registered read beat data |
| rdOe | output | 1 | Read bus driven (low means high impedance) |
| echoValid | output | 1 | Echo clock running indication |

## Verification
The command path is driven with deselects, read–read pairs, write–write pairs, reads overlapped by writes with both strobes low, and a fully alternating read/write stream. Each pattern separates one arbitration rule from the others. Reading back the address of an ignored second write tells a suppressed command apart from an accepted one. Writes with complementary lane masks on the two beats show which beat each mask was sampled with. A read placed right after a write to the same address checks that the new data is returned.

// File: rtl/sepio_sram_pkg.sv
`timescale 1ns/1ps
package sepio_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // strobes from control to datapath for the current edge
  typedef struct packed {
    logic rdEn;
    logic rdLsb;
    logic wrEn;
    logic wrLsb;
  } strobe_t;
endpackage

// File: rtl/sepio_sram_ctrl.sv
`timescale 1ns/1ps
module sepio_sram_ctrl
  import sepio_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              readN,
  input  logic              writeN,
  output strobe_t           st,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              echoValid
);
  cmd_e prevCmd;
  cmd_e cmdNow;
  logic rdP0, rdP1, wrP0, wrP1;

  // arbitration against the command loaded on the previous edge
  always_comb begin
    cmdNow = CMD_IDLE;
    if (!readN && prevCmd != CMD_READ)
      cmdNow = CMD_READ;
    else if (!writeN && prevCmd != CMD_WRITE)
      cmdNow = CMD_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCmd   <= CMD_IDLE;
      rdP0      <= 1'b0;
      rdP1      <= 1'b0;
      wrP0      <= 1'b0;
      wrP1      <= 1'b0;
      echoValid <= 1'b0;
    end else begin
      prevCmd   <= cmdNow;
      rdP0      <= (cmdNow == CMD_READ);
      rdP1      <= rdP0;
      wrP0      <= (cmdNow == CMD_WRITE);
      wrP1      <= wrP0;
      echoValid <= 1'b1;
    end
  end

  // the old address is still used by beat 1 on the edge a new one loads
  always_ff @(posedge clk) begin
    if (cmdNow == CMD_READ)  rdAddr <= addrIn;
    if (cmdNow == CMD_WRITE) wrAddr <= addrIn;
  end

  always_comb begin
    st.rdEn  = rdP0 | rdP1;
    st.rdLsb = rdP1;
    st.wrEn  = wrP0 | wrP1;
    st.wrLsb = wrP1;
  end

  assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (readN && writeN) |=> (!rdP0 && !wrP0));
  assert_no_back_read_R2: assert property (@(posedge clk) disable iff (rst)
    rdP0 |=> !rdP0);
  assert_no_back_write_R3: assert property (@(posedge clk) disable iff (rst)
    wrP0 |=> !wrP0);
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (rst)
    (rdP0 && !writeN) |=> wrP0);
endmodule

// File: rtl/sepio_sram_data.sv
`timescale 1ns/1ps
module sepio_sram_data
  import sepio_sram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 st,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        byteEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdOe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wIdx, rIdx;

  assign wIdx = {wrAddr, st.wrLsb};
  assign rIdx = {rdAddr, st.rdLsb};

  always_ff @(posedge clk) begin
    if (st.wrEn) begin
      for (int i = 0; i < LANES; i++) begin
        if (!byteEnN[i]) mem[wIdx][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdOe   <= 1'b0;
      rdData <= '0;
    end else begin
      rdOe <= st.rdEn;
      if (st.rdEn) rdData <= mem[rIdx];
    end
  end

  assert_write_beat_order_R5: assert property (@(posedge clk) disable iff (rst)
    (st.wrEn && st.wrLsb) |-> $past(st.wrEn && !st.wrLsb));
  assert_read_beat_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (st.rdEn && !st.rdLsb) |=> (st.rdEn && st.rdLsb));
endmodule

// File: rtl/sepio_burst_sram.sv
`timescale 1ns/1ps
module sepio_burst_sram
  import sepio_sram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    readN,
  input  logic                    writeN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [LANES-1:0]        byteEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdOe,
  output logic                    echoValid
);
  strobe_t           st;
  logic [ADDR_W-1:0] rdAddr, wrAddr;

  sepio_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addrIn(addrIn), .readN(readN), .writeN(writeN),
    .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr), .echoValid(echoValid)
  );

  sepio_sram_data #(.LANES(LANES), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst(rst), .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrData(wrData), .byteEnN(byteEnN), .rdData(rdData), .rdOe(rdOe)
  );

  assert_echo_steady_R11: assert property (@(posedge clk) disable iff (rst)
    $past(echoValid) |-> echoValid);
endmodule

// File: tb/sepio_burst_sram_bench.sv
`timescale 1ns/1ps
module sepio_burst_sram_bench;
  localparam int LANES = 2;
  localparam int AW    = 4;
  localparam int DW    = LANES * 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic readN = 1'b1, writeN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [LANES-1:0] byteEnN = '1;
  logic [DW-1:0] rdData;
  logic rdOe, echoValid;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sepio_burst_sram #(.LANES(LANES), .ADDR_W(AW)) u_sepio_burst_sram (
    .clk(clk), .rst(rst), .addrIn(addrIn), .readN(readN), .writeN(writeN),
    .wrData(wrData), .byteEnN(byteEnN), .rdData(rdData), .rdOe(rdOe),
    .echoValid(echoValid)
  );

  typedef struct { logic oe; logic [DW-1:0] d; string tag; } exp_t;
  exp_t q[$];

  // reference model state, built from the requirements
  logic [DW-1:0] mmem [1 << (AW+1)];
  int mPrev = 0;
  bit mRd0 = 0, mRd1 = 0, mWr0 = 0, mWr1 = 0;
  logic [AW-1:0] mRA = '0, mWA = '0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic rN, input logic wN, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [LANES-1:0] be, input string tag);
    int cmd;
    exp_t e;
    readN = rN; writeN = wN; addrIn = a; wrData = wd; byteEnN = be;
    @(posedge clk);
    cmd = 0;
    if (!rN && mPrev != 1) cmd = 1;
    else if (!wN && mPrev != 2) cmd = 2;
    if (mWr0 || mWr1) begin
      for (int i = 0; i < LANES; i++)
        if (!be[i]) mmem[{mWA, mWr1}][i*9 +: 9] = wd[i*9 +: 9];
    end
    e.oe = mRd0 | mRd1;
    e.d = e.oe ? mmem[{mRA, mRd1}] : '0;
    e.tag = tag;
    q.push_back(e);
    mRd1 = mRd0; mRd0 = (cmd == 1);
    mWr1 = mWr0; mWr0 = (cmd == 2);
    if (cmd == 1) mRA = a;
    if (cmd == 2) mWA = a;
    mPrev = cmd;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b1, '0, '0, '1, tag);
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(rdOe === e.oe, "R10", {{(DW-1){1'b0}}, rdOe}, {{(DW-1){1'b0}}, e.oe});
      check(echoValid === 1'b1, "R11", {{(DW-1){1'b0}}, echoValid}, 1);
      if (e.oe) check(rdData === e.d, e.tag, rdData, e.d);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdOe === 1'b0, "R12", {{(DW-1){1'b0}}, rdOe}, 0);
    check(echoValid === 1'b0, "R12", {{(DW-1){1'b0}}, echoValid}, 0);
    rst = 1'b0;

    idle("R1"); idle("R1");
    // seed addresses 6 and 2
    step(1, 0, 6, '0, '1, "R3");
    step(1, 1, 0, 18'h2A5A5, 2'b00, "R6");
    step(1, 1, 0, 18'h15A5A, 2'b00, "R6");
    step(1, 0, 2, '0, '1, "R3");
    step(1, 1, 0, 18'h11111, 2'b00, "R6");
    step(1, 1, 0, 18'h22222, 2'b00, "R6");
    // write 3 then read it at once (R9)
    step(1, 0, 3, '0, '1, "R3");
    step(0, 1, 3, 18'h3C0F0, 2'b00, "R9");
    step(1, 1, 0, 18'h0F3C3, 2'b00, "R9");
    idle("R9"); idle("R7"); idle("R10");
    // back-to-back reads: second ignored (R2)
    step(0, 1, 3, '0, '1, "R2");
    step(0, 1, 6, '0, '1, "R2");
    idle("R5"); idle("R2"); idle("R10");
    // back-to-back writes: second (to 6) ignored (R3)
    step(1, 0, 5, '0, '1, "R3");
    step(1, 0, 6, 18'h12345, 2'b00, "R6");
    step(1, 1, 0, 18'h23456, 2'b00, "R6");
    step(1, 1, 0, 18'h3FFFF, 2'b00, "R3");
    step(0, 1, 6, '0, '1, "R3");
    idle("R3"); idle("R3");
    // read then write with both strobes low (R4)
    step(0, 1, 5, '0, '1, "R5");
    step(0, 0, 7, '0, '1, "R4");
    step(1, 1, 0, 18'h01234, 2'b00, "R5");
    step(1, 1, 0, 18'h30201, 2'b00, "R4");
    step(0, 1, 7, '0, '1, "R4");
    idle("R4"); idle("R4");
    // both strobes low after a non-read: read wins (R2)
    idle("R1");
    step(0, 0, 2, '0, '1, "R2");
    idle("R2"); idle("R2");
    // complementary lane masks on the two beats (R8)
    step(1, 0, 2, '0, '1, "R8");
    step(1, 1, 0, 18'h3FFFF, 2'b10, "R8");
    step(1, 1, 0, 18'h3FFFF, 2'b01, "R8");
    step(0, 1, 2, '0, '1, "R8");
    idle("R8"); idle("R8");
    // aborted write (all enables high) leaves 3 unchanged (R8)
    step(1, 0, 3, '0, '1, "R8");
    step(1, 1, 0, 18'h00000, 2'b11, "R8");
    step(1, 1, 0, 18'h00000, 2'b11, "R8");
    step(0, 1, 3, '0, '1, "R8");
    idle("R8"); idle("R8");
    // alternating stream R W R W
    step(0, 1, 2, '0, '1, "R7");
    step(1, 0, 4, '0, '1, "R7");
    step(0, 1, 4, 18'h0ABCD, 2'b00, "R9");
    step(1, 0, 3, 18'h1DCBA, 2'b00, "R9");
    step(1, 1, 0, 18'h05555, 2'b00, "R6");
    step(1, 1, 0, 18'h0AAAA, 2'b00, "R6");
    step(0, 1, 3, '0, '1, "R6");
    idle("R6"); idle("R6");
    idle("R10"); idle("R10");
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule